// File: doc/BRIEF.md
# Bidirectional Line Direction Arbiter

This block steers a half-duplex, single-wire data path that joins a host-facing line to a card-facing line. Both lines are open-drain with passive pullups, so either end may pull its own line low at any time. The arbiter watches both lines. The side whose falling edge it sees first becomes the master, and the opposite side becomes the slave. After a programmable settling delay the arbiter turns on the slave-side pulldown, so the low level is copied across. When the master lets its line go high, the arbiter drops the slave pulldown and turns on a slave-side active pullup for a fixed number of cycles. This gives a fast rising edge. It then returns to idle with nothing driven.

There are `NUM_CH` identical channels, three by default: the main data line and two auxiliary lines. Each channel has its own enable. Both sensed line levels pass through a `SYNC_STAGES`-deep synchronizer before falling-edge detection. Each channel's state machine has four states: `ST_IDLE`, `ST_WAIT` (settling delay running), `ST_DRIVE` (slave pulldown on) and `ST_PULLUP` (slave active pullup on). The transitions are:
- `T_EDGE_HOST` and `T_EDGE_CARD`: IDLE to WAIT, which records the master side.
- `T_DELAY_DONE`: WAIT to DRIVE.
- `T_ABORT`: WAIT to IDLE, when the master releases before the delay ends.
- `T_RELEASE`: DRIVE to PULLUP.
- `T_PU_DONE`: PULLUP to IDLE.
- `T_DISABLE`: any state to IDLE, when the channel enable is low.

Top module: `bidir_line_arbiter`

## Requirements
- R1: After reset, and in the idle state, every pulldown enable and every active-pullup enable of every channel is low.
- R2: When the host line of an enabled idle channel falls, the host becomes master. The card pulldown turns on at the (EDGE_DLY+3)-th rising edge, counting the first edge that samples the low level. It stays on while the host line is held low.
- R3: When the card line falls first, the card becomes master and the host pulldown turns on with the same latency as in R2.
- R4: When both lines of an idle channel fall in the same sampled cycle, the host becomes master and the card side is the one pulled down.
- R5: While a master is established and the slave pulldown is on, level changes on the slave side's external line do not alter any enable of the channel.
- R6: After the master line returns high, the slave pulldown turns off and the slave active pullup turns on at the third rising edge, counting the first edge that samples the high level. The pullup stays on for exactly PU_CYC cycles, and then all enables of the channel are low.
- R7: If the master line returns high after being low for no more than EDGE_DLY sampled cycles, the transfer is abandoned: neither the slave pulldown nor any pullup turns on.
- R8: The two pulldowns of a channel are never on together. A side's pulldown and active pullup are never on together. The master side is never driven.
- R9: When a channel's enable is low, all four of its enables are low in the same cycle and its arbiter returns to idle. Line activity while disabled starts nothing. After re-enabling, a line that is already low starts nothing until a fresh falling edge.
- R10: Channels are independent: a transfer on one channel leaves every enable of the other channels low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | NUM_CH | Per-channel enable; low forces the channel idle and undriven |
| host_line_i | input | NUM_CH | Sensed level of each host-side line |
| card_line_i | input | NUM_CH | Sensed level of each card-side line |
| host_pd_o | output | NUM_CH | Host-side pulldown enable |
| host_pu_o | output | NUM_CH | Host-side active-pullup enable |
| card_pd_o | output | NUM_CH | Card-side pulldown enable |
| card_pu_o | output | NUM_CH | Card-side active-pullup enable |

## Verification
A line change applied between clock edges is captured at the next rising edge. It spends SYNC_STAGES edges in the synchronizer and one more edge moving the state machine. The slave pulldown therefore appears EDGE_DLY+3 edges after a fall. The pullup appears three edges after a release and lasts PU_CYC cycles. The enable acts combinationally on the outputs, within the same cycle. The bench drives lines on the falling clock edge and samples after every following rising edge. For each edge index it computes which enable must be on from these counts, so an output one cycle early or late is caught. The bench models each wire as its external driver ANDed with the block's own pulldown, so the slave line really goes low while the slave edge is being ignored.

// File: rtl/lda_pkg.sv
package lda_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WAIT   = 2'd1,
        ST_DRIVE  = 2'd2,
        ST_PULLUP = 2'd3
    } arb_state_e;

    typedef enum logic {
        SIDE_HOST = 1'b0,
        SIDE_CARD = 1'b1
    } side_e;

    typedef struct packed {
        logic pd;
        logic pu;
    } side_drv_t;

endpackage

// File: rtl/lda_sync.sv
// Level synchronizer with registered falling-edge detector.
module lda_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic fall
);

    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= RST_VAL;
        else        prev <= chain[STAGES-1];
    end

    assign q    = chain[STAGES-1];
    assign fall = prev & ~chain[STAGES-1];

endmodule

// File: rtl/lda_chan_fsm.sv
// Per-channel direction state machine.
module lda_chan_fsm
    import lda_pkg::*;
#(
    parameter int EDGE_DLY = 4,
    parameter int PU_CYC   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic host_lvl,
    input  logic card_lvl,
    input  logic host_fall,
    input  logic card_fall,
    output logic host_pd,
    output logic host_pu,
    output logic card_pd,
    output logic card_pu
);

    localparam int CNT_MAX = (EDGE_DLY > PU_CYC) ? EDGE_DLY : PU_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(EDGE_DLY - 1);
    localparam logic [CNT_W-1:0] PU_LAST  = CNT_W'(PU_CYC - 1);

    arb_state_e       state, nxt_state;
    side_e            master, nxt_master;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             master_lvl;
    side_drv_t        host_drv, card_drv;

    assign master_lvl = (master == SIDE_HOST) ? host_lvl : card_lvl;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            master <= SIDE_HOST;
            cnt    <= '0;
        end else begin
            state  <= nxt_state;
            master <= nxt_master;
            cnt    <= cnt_nxt;
        end
    end

    // Transitions
    always_comb begin
        nxt_state  = state;
        nxt_master = master;
        cnt_nxt    = cnt + CNT_W'(1);
        if (!en) begin
            // T_DISABLE
            nxt_state = ST_IDLE;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt_nxt = '0;
                    if (host_fall) begin
                        // T_EDGE_HOST: host wins a same-cycle tie
                        nxt_state  = ST_WAIT;
                        nxt_master = SIDE_HOST;
                    end else if (card_fall) begin
                        // T_EDGE_CARD
                        nxt_state  = ST_WAIT;
                        nxt_master = SIDE_CARD;
                    end
                end
                ST_WAIT: begin
                    if (master_lvl) begin
                        // T_ABORT: release beats delay completion
                        nxt_state = ST_IDLE;
                        cnt_nxt   = '0;
                    end else if (cnt == DLY_LAST) begin
                        // T_DELAY_DONE
                        nxt_state = ST_DRIVE;
                        cnt_nxt   = '0;
                    end
                end
                ST_DRIVE: begin
                    cnt_nxt = '0;
                    if (master_lvl) begin
                        // T_RELEASE
                        nxt_state = ST_PULLUP;
                    end
                end
                ST_PULLUP: begin
                    if (cnt == PU_LAST) begin
                        // T_PU_DONE
                        nxt_state = ST_IDLE;
                        cnt_nxt   = '0;
                    end
                end
                default: begin
                    nxt_state = ST_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    // Outputs: only the slave side is ever driven
    always_comb begin
        host_drv = '0;
        card_drv = '0;
        if (en) begin
            unique case (state)
                ST_DRIVE: begin
                    if (master == SIDE_HOST) card_drv.pd = 1'b1;
                    else                     host_drv.pd = 1'b1;
                end
                ST_PULLUP: begin
                    if (master == SIDE_HOST) card_drv.pu = 1'b1;
                    else                     host_drv.pu = 1'b1;
                end
                default: begin
                    host_drv = '0;
                    card_drv = '0;
                end
            endcase
        end
    end

    assign host_pd = host_drv.pd;
    assign host_pu = host_drv.pu;
    assign card_pd = card_drv.pd;
    assign card_pu = card_drv.pu;

endmodule

// File: rtl/bidir_line_arbiter.sv
// Multi-channel bidirectional line direction arbiter.
module bidir_line_arbiter #(
    parameter int NUM_CH      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int EDGE_DLY    = 4,
    parameter int PU_CYC      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] chan_en,
    input  logic [NUM_CH-1:0] host_line_i,
    input  logic [NUM_CH-1:0] card_line_i,
    output logic [NUM_CH-1:0] host_pd_o,
    output logic [NUM_CH-1:0] host_pu_o,
    output logic [NUM_CH-1:0] card_pd_o,
    output logic [NUM_CH-1:0] card_pu_o
);

    logic [NUM_CH-1:0] host_lvl, card_lvl, host_fall, card_fall;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            lda_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(1'b1)
            ) host_sync_i (
                .clk (clk),
                .rst_n(rst_n),
                .d   (host_line_i[g]),
                .q   (host_lvl[g]),
                .fall(host_fall[g])
            );

            lda_sync #(
                .STAGES (SYNC_STAGES),
                .RST_VAL(1'b1)
            ) card_sync_i (
                .clk (clk),
                .rst_n(rst_n),
                .d   (card_line_i[g]),
                .q   (card_lvl[g]),
                .fall(card_fall[g])
            );

            lda_chan_fsm #(
                .EDGE_DLY(EDGE_DLY),
                .PU_CYC  (PU_CYC)
            ) fsm_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .en       (chan_en[g]),
                .host_lvl (host_lvl[g]),
                .card_lvl (card_lvl[g]),
                .host_fall(host_fall[g]),
                .card_fall(card_fall[g]),
                .host_pd  (host_pd_o[g]),
                .host_pu  (host_pu_o[g]),
                .card_pd  (card_pd_o[g]),
                .card_pu  (card_pu_o[g])
            );
        end
    endgenerate

endmodule

// File: rtl/lda_checker.sv
module lda_checker #(
    parameter int NUM_CH = 3,
    parameter int PU_CYC = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] chan_en,
    input logic [NUM_CH-1:0] host_pd_o,
    input logic [NUM_CH-1:0] host_pu_o,
    input logic [NUM_CH-1:0] card_pd_o,
    input logic [NUM_CH-1:0] card_pu_o
);

    localparam int RW = $clog2(PU_CYC + 2);

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
            logic [RW-1:0] pu_run;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                          pu_run <= '0;
                else if (host_pu_o[g] | card_pu_o[g]) begin
                    if (pu_run != '1) pu_run <= pu_run + RW'(1);
                end else                             pu_run <= '0;
            end

            AST_PD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
                !(host_pd_o[g] && card_pd_o[g])); // R8

            AST_SIDE_NO_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
                !(host_pd_o[g] && host_pu_o[g]) && !(card_pd_o[g] && card_pu_o[g])); // R8

            AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
                !chan_en[g] |-> !(host_pd_o[g] | host_pu_o[g] | card_pd_o[g] | card_pu_o[g])); // R9

            AST_HOST_PU_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(host_pu_o[g]) |-> $past(host_pd_o[g])); // R6

            AST_CARD_PU_AFTER_PD: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(card_pu_o[g]) |-> $past(card_pd_o[g])); // R6

            AST_PU_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
                (host_pu_o[g] | card_pu_o[g]) |-> (pu_run < RW'(PU_CYC))); // R6
        end
    endgenerate

endmodule

bind bidir_line_arbiter lda_checker #(
    .NUM_CH(NUM_CH),
    .PU_CYC(PU_CYC)
) lda_checker_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (chan_en),
    .host_pd_o(host_pd_o),
    .host_pu_o(host_pu_o),
    .card_pd_o(card_pd_o),
    .card_pu_o(card_pu_o)
);

// File: tb/bidir_line_arbiter_tb_top.sv
module bidir_line_arbiter_tb_top;

    localparam int NCH = 3;
    localparam int D   = 4;
    localparam int PU  = 3;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic           rst_n;
    logic [NCH-1:0] chan_en, host_ext, card_ext;
    logic [NCH-1:0] host_pd, host_pu, card_pd, card_pu;
    logic [NCH-1:0] host_line, card_line;

    // Open-drain wire model: low if the outside pulls low or the block's pulldown is on
    assign host_line = host_ext & ~host_pd;
    assign card_line = card_ext & ~card_pd;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bidir_line_arbiter #(
        .NUM_CH     (NCH),
        .SYNC_STAGES(2),
        .EDGE_DLY   (D),
        .PU_CYC     (PU)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .chan_en    (chan_en),
        .host_line_i(host_line),
        .card_line_i(card_line),
        .host_pd_o  (host_pd),
        .host_pu_o  (host_pu),
        .card_pd_o  (card_pd),
        .card_pu_o  (card_pu)
    );

    // Vector: {channel[1:0], start[1:0] (1 host, 2 card, 3 both), low_len[7:0], slave_is_card}
    localparam int NVEC = 8;
    localparam logic [12:0] VECS [NVEC] = '{
        {2'd0, 2'd1, 8'd10, 1'b1},   // R2
        {2'd1, 2'd2, 8'd10, 1'b0},   // R3
        {2'd2, 2'd3, 8'd8,  1'b1},   // R4
        {2'd0, 2'd1, 8'd3,  1'b1},   // R7 short pulse
        {2'd1, 2'd2, 8'd5,  1'b0},   // R3 boundary D+1
        {2'd2, 2'd2, 8'd4,  1'b0},   // R7 boundary D
        {2'd0, 2'd2, 8'd20, 1'b0},   // R3 long hold
        {2'd1, 2'd1, 8'd6,  1'b1}    // R2
    };

    task automatic chk(input logic [NCH-1:0] act, input logic [NCH-1:0] exp,
                       input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic chk_quiet(input string req, input string what);
        chk(host_pd | host_pu | card_pd | card_pu, '0, req, what);
    endtask

    task automatic run_vec(input int ch, input int start, input int low, input bit slave_card);
        logic [NCH-1:0] msk;
        logic [NCH-1:0] spd, spu, mdrv;
        bit    driven;
        bit    pd_e, pu_e;
        string tag;
        msk    = NCH'(1) << ch;
        driven = (low > D);
        tag    = (start == 3) ? "R4" : ((start == 1) ? "R2" : "R3");
        @(negedge clk);
        if ((start & 1) != 0) host_ext[ch] = 1'b0;
        if ((start & 2) != 0) card_ext[ch] = 1'b0;
        for (int e = 1; e <= low + PU + 6; e++) begin
            @(posedge clk);
            @(negedge clk);
            pd_e = driven && (e >= D + 3) && (e <= low + 2);
            pu_e = driven && (e >= low + 3) && (e <= low + 2 + PU);
            spd  = slave_card ? card_pd : host_pd;
            spu  = slave_card ? card_pu : host_pu;
            mdrv = slave_card ? (host_pd | host_pu) : (card_pd | card_pu);
            chk(spd & msk, pd_e ? msk : '0, driven ? tag : "R7", "slave pulldown");
            chk(spu & msk, pu_e ? msk : '0, driven ? "R6" : "R7", "slave pullup");
            chk(mdrv & msk, '0, "R8", "master side drive");
            chk((host_pd | host_pu | card_pd | card_pu) & ~msk, '0, "R10", "other channels");
            if (e == low) begin
                host_ext[ch] = 1'b1;
                card_ext[ch] = 1'b1;
            end
        end
    endtask

    initial begin
        rst_n    = 1'b0;
        chan_en  = '1;
        host_ext = '1;
        card_ext = '1;
        repeat (5) @(negedge clk);
        chk_quiet("R1", "enables during reset");
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk_quiet("R1", "enables after reset");
        end

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            run_vec(int'(VECS[i][12:11]), int'(VECS[i][10:9]), int'(VECS[i][8:1]), VECS[i][0]);
        end

        // R5: slave-side toggles while the host holds the line
        @(negedge clk);
        host_ext[0] = 1'b0;
        repeat (D + 4) @(negedge clk);
        chk(card_pd, 3'b001, "R5", "card pulldown before slave toggles");
        for (int k = 0; k < 6; k++) begin
            card_ext[0] = k[0];
            @(negedge clk);
            chk(card_pd, 3'b001, "R5", "card pulldown during slave toggles");
            chk(host_pd | host_pu | card_pu, '0, "R5", "no other enable during slave toggles");
        end
        card_ext[0] = 1'b1;
        host_ext[0] = 1'b0;
        @(negedge clk);
        host_ext[0] = 1'b1;
        repeat (3) @(negedge clk);
        chk(card_pu, 3'b001, "R6", "pullup after directed release");
        repeat (PU + 2) @(negedge clk);
        chk_quiet("R6", "idle after directed pullup");

        // R9: disable mid-transfer, activity while disabled, re-enable with a low line
        host_ext[1] = 1'b0;
        repeat (D + 4) @(negedge clk);
        chk(card_pd, 3'b010, "R9", "pulldown before disable");
        chan_en[1] = 1'b0;
        #1;
        chk_quiet("R9", "enables drop in the disabling cycle");
        card_ext[1] = 1'b0;
        repeat (8) begin
            @(negedge clk);
            chk_quiet("R9", "quiet while disabled");
        end
        chan_en[1] = 1'b1;
        repeat (8) begin
            @(negedge clk);
            chk_quiet("R9", "no start from a stale low level");
        end
        host_ext[1] = 1'b1;
        card_ext[1] = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk_quiet("R9", "quiet after lines restored");
        end
        run_vec(1, 1, 6, 1'b1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1-run did not complete actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule